// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block decides, one cycle after a translated access is presented, whether that access may go ahead. It receives the matched descriptor's domain number, its access-permission field or fields, and its region kind. It also receives the access direction, the privilege level, two protection control bits and the translation enable. It holds the domain mode register, which has one two-bit field per domain. The domain mode either blocks the access outright, passes it without looking at the permissions, or hands it to the permission check.

For the two page kinds that are split into quarter subpages, the permission field is chosen from virtual address bits. Sections and tiny pages use a single field. When an access is refused, the block raises an abort. In the same cycle it records the domain and fault type in a 9-bit status register and the virtual address in an address register. Software can load both registers directly, for example to restore them after a context switch.

Top module: `acc_perm_guard`

## Requirements
- R1: After reset, `resp_valid`, `grant` and `abort` are 0, and `dacr_q`, `fsr_q` and `far_q` are all zero.
- R2: An access sampled with `acc_valid` = 1 produces `resp_valid` = 1 on the next cycle with exactly one of `grant` or `abort` set. A cycle without `acc_valid` produces no response.
- R3: The domain mode is the `dacr_q` field at bits [2d+1:2d] for domain d. Mode 00 (deny) and mode 10 (reserved) abort the access with a domain fault.
- R4: Mode 11 (manager) grants the access whatever the permission field, direction or privilege.
- R5: In mode 01 (client), permission code 01 allows privileged read/write only, code 10 allows privileged read/write and user read, and code 11 allows all accesses.
- R6: Permission code 00 depends on the protection bits. `sys_prot`=1 with `rom_prot`=0 allows privileged reads only. `sys_prot`=0 with `rom_prot`=1 allows reads at any level. Any other combination allows nothing.
- R7: `desc_kind` is 0 for a section, 1 for a large page, 2 for a small page and 3 for a tiny page. Large pages use `acc_va[15:14]` and small pages use `acc_va[11:10]` to select field k, `desc_ap[2k+1:2k]`. Sections and tiny pages always use `desc_ap[1:0]`.
- R8: On an abort, `fsr_q` is set to {0, domain[3:0], type[3:0]}. The type codes are: section domain fault 1001, page domain fault 1011, section permission fault 1101, page permission fault 1111. Bit 8 is always 0.
- R9: On an abort, `far_q` takes the access's virtual address. A granted access leaves `fsr_q` and `far_q` unchanged.
- R10: `dacr_we`, `fsr_we` and `far_we` load their registers on the next edge. `fsr_we` loads bits [7:0].
- R11: When a fault capture and a software write reach the status or address register in the same cycle, the capture wins.
- R12: With `mmu_en` = 0, every access is granted and no fault is recorded.
- R13: Descriptor and address inputs presented while `acc_valid` = 0 have no effect on the outputs or on the fault registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_en | input | 1 | Translation enable; 0 turns off all checking |
| sys_prot | input | 1 | Protection bit: privileged read for permission code 00 |
| rom_prot | input | 1 | Protection bit: read at any level for permission code 00 |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged, 0 = user |
| acc_va | input | 32 | Virtual address of the access |
| desc_kind | input | 2 | Region kind: 0 section, 1 large, 2 small, 3 tiny |
| desc_dom | input | 4 | Domain number from the descriptor |
| desc_ap | input | 8 | Four two-bit permission fields |
| dacr_we | input | 1 | Domain mode register write strobe |
| dacr_wdata | input | 32 | Domain mode register write data |
| dacr_q | output | 32 | Domain mode register contents |
| fsr_we | input | 1 | Fault status write strobe |
| fsr_wdata | input | 8 | Fault status write data |
| fsr_q | output | 9 | Fault status register |
| far_we | input | 1 | Fault address write strobe |
| far_wdata | input | 32 | Fault address write data |
| far_q | output | 32 | Fault address register |
| resp_valid | output | 1 | Verdict present |
| grant | output | 1 | Access allowed |
| abort | output | 1 | Access refused |

## Verification
On every cycle, the assertions check the response handshake: one response per access and exactly one verdict. They also check that manager and deny modes override the permission field, that a disabled translation always grants, and that the fault registers follow capture-over-write priority. Only the bench scenarios show the detailed permission decoding. That covers each permission code against every direction, privilege and protection-bit combination, subpage selection by the correct address bits for each region kind, and the exact fault type codes.

// File: rtl/apg_pkg.sv
package apg_pkg;

   typedef enum logic [1:0] {
      RK_SECTION = 2'd0,
      RK_LARGE   = 2'd1,
      RK_SMALL   = 2'd2,
      RK_TINY    = 2'd3
   } region_kind_e;

   typedef enum logic [1:0] {
      DM_DENY    = 2'd0,
      DM_CLIENT  = 2'd1,
      DM_RSVD    = 2'd2,
      DM_MANAGER = 2'd3
   } dom_mode_e;

   typedef enum logic [1:0] {
      AP_SPECIAL = 2'd0,
      AP_PRIV_RW = 2'd1,
      AP_USER_RO = 2'd2,
      AP_ALL_RW  = 2'd3
   } ap_code_e;

   localparam int FT_W = 4;
   localparam logic [FT_W-1:0] FT_DOM_SECT  = 4'b1001;
   localparam logic [FT_W-1:0] FT_DOM_PAGE  = 4'b1011;
   localparam logic [FT_W-1:0] FT_PERM_SECT = 4'b1101;
   localparam logic [FT_W-1:0] FT_PERM_PAGE = 4'b1111;

   typedef struct packed {
      logic            allow;
      logic [FT_W-1:0] ftype;
   } verdict_t;

endpackage

// File: rtl/apg_domain_reg.sv
module apg_domain_reg
   import apg_pkg::*;
#(
   parameter  int NUM_DOM = 16,
   localparam int DOM_W   = $clog2(NUM_DOM),
   localparam int REG_W   = 2 * NUM_DOM
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   input  logic [DOM_W-1:0] sel,
   output dom_mode_e        mode,
   output logic [REG_W-1:0] q
);

   if (NUM_DOM < 2 || (1 << DOM_W) != NUM_DOM) begin : g_bad_dom
      $error("apg_domain_reg: NUM_DOM must be a power of two >= 2");
   end

   logic [REG_W-1:0] regq;
   logic [1:0]       field [NUM_DOM];

   always_ff @(posedge clk) begin
      if (!rst_n)  regq <= '0;
      else if (we) regq <= wdata;
   end

   for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
      assign field[g] = regq[2*g +: 2];
   end

   assign mode = dom_mode_e'(field[sel]);
   assign q    = regq;

   // R10
   dacr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> q == $past(wdata));

endmodule

// File: rtl/apg_ap_select.sv
module apg_ap_select
   import apg_pkg::*;
#(
   parameter  int NUM_SUB = 4,
   parameter  int AP_W    = 2,
   localparam int SUB_W   = $clog2(NUM_SUB)
)(
   input  region_kind_e             kind,
   input  logic [SUB_W-1:0]         large_sel,
   input  logic [SUB_W-1:0]         small_sel,
   input  logic [NUM_SUB*AP_W-1:0]  ap_vec,
   output logic [AP_W-1:0]          ap_out
);

   if (NUM_SUB < 2 || (1 << SUB_W) != NUM_SUB) begin : g_bad_sub
      $error("apg_ap_select: NUM_SUB must be a power of two >= 2");
   end

   logic [AP_W-1:0] sub_ap [NUM_SUB];

   for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
      assign sub_ap[g] = ap_vec[g*AP_W +: AP_W];
   end

   always_comb begin
      case (kind)
         RK_LARGE: ap_out = sub_ap[large_sel];
         RK_SMALL: ap_out = sub_ap[small_sel];
         default:  ap_out = sub_ap[0];
      endcase
   end

endmodule

// File: rtl/apg_perm_eval.sv
module apg_perm_eval
   import apg_pkg::*;
#(
   parameter bit RSVD_IS_FAULT = 1'b1
)(
   input  logic      mmu_en,
   input  dom_mode_e mode,
   input  ap_code_e  ap,
   input  logic      is_write,
   input  logic      is_priv,
   input  logic      is_page,
   input  logic      sys_prot,
   input  logic      rom_prot,
   output verdict_t  v
);

   logic rsvd_fault;
   logic perm_ok;
   logic dom_fault;
   logic dom_bypass;

   if (RSVD_IS_FAULT) begin : g_rsvd_fault
      assign rsvd_fault = 1'b1;
   end else begin : g_rsvd_bypass
      assign rsvd_fault = 1'b0;
   end

   always_comb begin
      case (ap)
         AP_SPECIAL: begin
            case ({sys_prot, rom_prot})
               2'b10:   perm_ok = is_priv && !is_write;
               2'b01:   perm_ok = !is_write;
               default: perm_ok = 1'b0;
            endcase
         end
         AP_PRIV_RW: perm_ok = is_priv;
         AP_USER_RO: perm_ok = is_priv || !is_write;
         default:    perm_ok = 1'b1;
      endcase
   end

   always_comb begin
      dom_fault  = 1'b0;
      dom_bypass = 1'b0;
      case (mode)
         DM_DENY:    dom_fault  = 1'b1;
         DM_RSVD:    begin
            dom_fault  = rsvd_fault;
            dom_bypass = !rsvd_fault;
         end
         DM_MANAGER: dom_bypass = 1'b1;
         default:    ;
      endcase
   end

   always_comb begin
      if (!mmu_en) begin
         v.allow = 1'b1;
         v.ftype = '0;
      end else if (dom_fault) begin
         v.allow = 1'b0;
         v.ftype = is_page ? FT_DOM_PAGE : FT_DOM_SECT;
      end else if (dom_bypass || perm_ok) begin
         v.allow = 1'b1;
         v.ftype = '0;
      end else begin
         v.allow = 1'b0;
         v.ftype = is_page ? FT_PERM_PAGE : FT_PERM_SECT;
      end
   end

endmodule

// File: rtl/apg_fault_regs.sv
module apg_fault_regs
   import apg_pkg::*;
#(
   parameter  int VA_W   = 32,
   parameter  int DOM_W  = 4,
   parameter  int FSR_W  = 9,
   localparam int LIVE_W = FSR_W - 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rec_en,
   input  logic [DOM_W-1:0]  rec_dom,
   input  logic [FT_W-1:0]   rec_type,
   input  logic [VA_W-1:0]   rec_va,
   input  logic              fsr_we,
   input  logic [LIVE_W-1:0] fsr_wdata,
   input  logic              far_we,
   input  logic [VA_W-1:0]   far_wdata,
   output logic [FSR_W-1:0]  fsr_q,
   output logic [VA_W-1:0]   far_q
);

   if (FT_W + DOM_W > LIVE_W) begin : g_bad_fsr
      $error("apg_fault_regs: status register too narrow for domain and type");
   end

   logic [LIVE_W-1:0] fsr_live;
   logic [LIVE_W-1:0] cap_word;
   logic [VA_W-1:0]   far_r;

   always_comb begin
      cap_word                = '0;
      cap_word[FT_W-1:0]      = rec_type;
      cap_word[FT_W +: DOM_W] = rec_dom;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsr_live <= '0;
         far_r    <= '0;
      end else if (rec_en) begin
         fsr_live <= cap_word;
         far_r    <= rec_va;
      end else begin
         if (fsr_we) fsr_live <= fsr_wdata;
         if (far_we) far_r    <= far_wdata;
      end
   end

   assign fsr_q = {1'b0, fsr_live};
   assign far_q = far_r;

   // R8
   fsr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_en |=> (fsr_q[FT_W-1:0] == $past(rec_type)) &&
                 (fsr_q[FT_W +: DOM_W] == $past(rec_dom)));

   // R9 R11
   far_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_en |=> far_q == $past(rec_va));

   // R10
   far_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rec_en && far_we) |=> far_q == $past(far_wdata));

   // R13
   far_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rec_en && !far_we) |=> $stable(far_q));

endmodule

// File: rtl/acc_perm_guard.sv
module acc_perm_guard
   import apg_pkg::*;
#(
   parameter  int VA_W          = 32,
   parameter  int NUM_DOM       = 16,
   parameter  int NUM_SUB       = 4,
   parameter  int LARGE_LSB     = 14,
   parameter  int SMALL_LSB     = 10,
   parameter  int FSR_W         = 9,
   parameter  bit RSVD_IS_FAULT = 1'b1,
   localparam int AP_W          = 2,
   localparam int DOM_W         = $clog2(NUM_DOM),
   localparam int SUB_W         = $clog2(NUM_SUB)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mmu_en,
   input  logic                    sys_prot,
   input  logic                    rom_prot,
   input  logic                    acc_valid,
   input  logic                    acc_write,
   input  logic                    acc_priv,
   input  logic [VA_W-1:0]         acc_va,
   input  logic [1:0]              desc_kind,
   input  logic [DOM_W-1:0]        desc_dom,
   input  logic [NUM_SUB*AP_W-1:0] desc_ap,
   input  logic                    dacr_we,
   input  logic [2*NUM_DOM-1:0]    dacr_wdata,
   output logic [2*NUM_DOM-1:0]    dacr_q,
   input  logic                    fsr_we,
   input  logic [FSR_W-2:0]        fsr_wdata,
   output logic [FSR_W-1:0]        fsr_q,
   input  logic                    far_we,
   input  logic [VA_W-1:0]         far_wdata,
   output logic [VA_W-1:0]         far_q,
   output logic                    resp_valid,
   output logic                    grant,
   output logic                    abort
);

   if (LARGE_LSB + SUB_W > VA_W || SMALL_LSB + SUB_W > VA_W) begin : g_bad_sel
      $error("acc_perm_guard: subpage select bits lie outside the address");
   end

   region_kind_e    kind;
   dom_mode_e       dom_mode;
   logic [AP_W-1:0] ap_raw;
   logic            is_page;
   verdict_t        verdict;
   logic            rec_en;

   assign kind    = region_kind_e'(desc_kind);
   assign is_page = (kind != RK_SECTION);

   apg_domain_reg #(.NUM_DOM(NUM_DOM)) u_dom (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (dacr_we),
      .wdata (dacr_wdata),
      .sel   (desc_dom),
      .mode  (dom_mode),
      .q     (dacr_q)
   );

   apg_ap_select #(.NUM_SUB(NUM_SUB), .AP_W(AP_W)) u_sel (
      .kind      (kind),
      .large_sel (acc_va[LARGE_LSB +: SUB_W]),
      .small_sel (acc_va[SMALL_LSB +: SUB_W]),
      .ap_vec    (desc_ap),
      .ap_out    (ap_raw)
   );

   apg_perm_eval #(.RSVD_IS_FAULT(RSVD_IS_FAULT)) u_eval (
      .mmu_en   (mmu_en),
      .mode     (dom_mode),
      .ap       (ap_code_e'(ap_raw)),
      .is_write (acc_write),
      .is_priv  (acc_priv),
      .is_page  (is_page),
      .sys_prot (sys_prot),
      .rom_prot (rom_prot),
      .v        (verdict)
   );

   assign rec_en = acc_valid && !verdict.allow;

   apg_fault_regs #(.VA_W(VA_W), .DOM_W(DOM_W), .FSR_W(FSR_W)) u_flt (
      .clk       (clk),
      .rst_n     (rst_n),
      .rec_en    (rec_en),
      .rec_dom   (desc_dom),
      .rec_type  (verdict.ftype),
      .rec_va    (acc_va),
      .fsr_we    (fsr_we),
      .fsr_wdata (fsr_wdata),
      .far_we    (far_we),
      .far_wdata (far_wdata),
      .fsr_q     (fsr_q),
      .far_q     (far_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         grant      <= 1'b0;
         abort      <= 1'b0;
      end else begin
         resp_valid <= acc_valid;
         grant      <= acc_valid && verdict.allow;
         abort      <= acc_valid && !verdict.allow;
      end
   end

   // R2
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (grant != abort));

   // R2
   resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> resp_valid);

   // R13
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!resp_valid && !grant && !abort));

   // R12
   mmu_off_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !mmu_en) |=> grant);

   // R4
   manager_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && mmu_en && dom_mode == DM_MANAGER) |=> grant);

   // R3
   deny_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && mmu_en && dom_mode == DM_DENY) |=> abort);

endmodule

// File: tb/tb_acc_perm_guard.sv
`timescale 1ns/1ps
module tb_acc_perm_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mmu_en = 1'b0, sys_prot = 1'b0, rom_prot = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0, acc_priv = 1'b0;
   logic [31:0] acc_va = '0;
   logic [1:0]  desc_kind = '0;
   logic [3:0]  desc_dom = '0;
   logic [7:0]  desc_ap = '0;
   logic        dacr_we = 1'b0;
   logic [31:0] dacr_wdata = '0;
   logic [31:0] dacr_q;
   logic        fsr_we = 1'b0;
   logic [7:0]  fsr_wdata = '0;
   logic [8:0]  fsr_q;
   logic        far_we = 1'b0;
   logic [31:0] far_wdata = '0;
   logic [31:0] far_q;
   logic        resp_valid, grant, abort;

   acc_perm_guard dut (.*);

   always #2 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [31:0] m_dacr = '0;
   logic [8:0]  m_fsr  = '0;
   logic [31:0] m_far  = '0;

   logic        q_grant [$];
   logic [8:0]  q_fsr   [$];
   logic [31:0] q_far   [$];
   string       q_req   [$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // Expected verdict from the requirements: {grant, fault type}
   function automatic logic [4:0] predict(input logic wr, input logic pv,
                                          input logic [1:0] kind, input logic [3:0] dom,
                                          input logic [7:0] ap, input logic [31:0] va);
      logic [1:0] fld;
      logic [1:0] a;
      logic       pg;
      logic       ok;
      fld = m_dacr[{dom, 1'b0} +: 2];
      pg  = (kind != 2'd0);
      if (!mmu_en) return {1'b1, 4'b0000};
      if (fld == 2'b00 || fld == 2'b10) return {1'b0, pg ? 4'b1011 : 4'b1001};
      if (fld == 2'b11) return {1'b1, 4'b0000};
      case (kind)
         2'd1:    a = ap[{va[15:14], 1'b0} +: 2];
         2'd2:    a = ap[{va[11:10], 1'b0} +: 2];
         default: a = ap[1:0];
      endcase
      case (a)
         2'b00: begin
            if (sys_prot && !rom_prot)      ok = pv && !wr;
            else if (!sys_prot && rom_prot) ok = !wr;
            else                            ok = 1'b0;
         end
         2'b01:   ok = pv;
         2'b10:   ok = pv || !wr;
         default: ok = 1'b1;
      endcase
      return ok ? {1'b1, 4'b0000} : {1'b0, pg ? 4'b1111 : 4'b1101};
   endfunction

   // Driver: presents one access and pushes the expected response
   task automatic access(input logic wr, input logic pv, input logic [1:0] kind,
                         input logic [3:0] dom, input logic [7:0] ap,
                         input logic [31:0] va, input string req,
                         input logic with_sw = 1'b0, input logic [7:0] sw_fsr = '0,
                         input logic [31:0] sw_far = '0);
      logic [4:0] p;
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_priv = pv; desc_kind = kind;
      desc_dom = dom; desc_ap = ap; acc_va = va;
      fsr_we = with_sw; fsr_wdata = sw_fsr; far_we = with_sw; far_wdata = sw_far;
      p = predict(wr, pv, kind, dom, ap, va);
      if (!p[4]) begin
         m_fsr = {1'b0, dom, p[3:0]};
         m_far = va;
      end else if (with_sw) begin
         m_fsr = {1'b0, sw_fsr};
         m_far = sw_far;
      end
      q_grant.push_back(p[4]);
      q_fsr.push_back(m_fsr);
      q_far.push_back(m_far);
      q_req.push_back(req);
      @(negedge clk);
      acc_valid = 1'b0; fsr_we = 1'b0; far_we = 1'b0;
   endtask

   // Monitor: pops and compares every response
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && resp_valid) begin
            if (q_req.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R2: actual unexpected response expected none");
            end else begin
               string r;
               logic  g;
               logic [8:0]  f;
               logic [31:0] a;
               r = q_req.pop_front(); g = q_grant.pop_front();
               f = q_fsr.pop_front(); a = q_far.pop_front();
               chk({r, " grant"}, 32'(grant), 32'(g));
               chk({r, " abort"}, 32'(abort), 32'(!g));
               chk({r, " fsr"}, 32'(fsr_q), 32'(f));
               chk({r, " far"}, far_q, a);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk("R1 resp_valid", 32'(resp_valid), 0);
      chk("R1 grant", 32'(grant), 0);
      chk("R1 abort", 32'(abort), 0);
      chk("R1 dacr", dacr_q, 0);
      chk("R1 fsr", 32'(fsr_q), 0);
      chk("R1 far", far_q, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R10 domain register load: d0 deny, d1 client, d2 reserved, d3 manager
      @(negedge clk);
      dacr_we = 1'b1; dacr_wdata = 32'h5555_55E4; m_dacr = 32'h5555_55E4;
      @(negedge clk);
      dacr_we = 1'b0;
      #1 chk("R10 dacr load", dacr_q, 32'h5555_55E4);

      mmu_en = 1'b1;
      access(0, 1, 2'd0, 4'd0, 8'hFF, 32'h0010_0000, "R3 R8 R9 deny section");
      access(0, 1, 2'd1, 4'd2, 8'hFF, 32'h0020_4000, "R3 R8 reserved page");
      access(1, 0, 2'd3, 4'd3, 8'h00, 32'h0030_0400, "R4 manager ignores AP");
      access(0, 0, 2'd0, 4'd1, 8'h55, 32'h0040_0000, "R5 AP01 user read");
      access(1, 1, 2'd0, 4'd1, 8'h55, 32'h0040_0004, "R5 AP01 priv write");
      access(0, 0, 2'd3, 4'd1, 8'hAA, 32'h0050_0000, "R5 AP10 user read");
      access(1, 0, 2'd3, 4'd1, 8'hAA, 32'h0050_0008, "R5 AP10 user write");
      access(1, 0, 2'd0, 4'd1, 8'hFF, 32'h0060_0000, "R5 AP11 user write");

      access(0, 1, 2'd0, 4'd1, 8'h00, 32'h0070_0000, "R6 AP00 neither bit");
      sys_prot = 1'b1;
      access(0, 1, 2'd0, 4'd1, 8'h00, 32'h0070_0010, "R6 S priv read");
      access(1, 1, 2'd0, 4'd1, 8'h00, 32'h0070_0020, "R6 S priv write");
      access(0, 0, 2'd0, 4'd1, 8'h00, 32'h0070_0030, "R6 S user read");
      sys_prot = 1'b0; rom_prot = 1'b1;
      access(0, 0, 2'd0, 4'd1, 8'h00, 32'h0070_0040, "R6 R user read");
      access(1, 1, 2'd0, 4'd1, 8'h00, 32'h0070_0050, "R6 R priv write");
      sys_prot = 1'b1;
      access(0, 1, 2'd0, 4'd1, 8'h00, 32'h0070_0060, "R6 both bits");
      sys_prot = 1'b0; rom_prot = 1'b0;

      // R7 subpages: ap0=00 ap1=01 ap2=10 ap3=11
      access(1, 0, 2'd1, 4'd1, 8'hE4, 32'h0000_C000, "R7 large sub3");
      access(0, 0, 2'd1, 4'd1, 8'hE4, 32'h0000_4000, "R7 large sub1");
      access(0, 0, 2'd1, 4'd1, 8'hE4, 32'h0000_0C00, "R7 large sub0");
      access(0, 0, 2'd2, 4'd1, 8'hE4, 32'h0000_0800, "R7 small sub2 read");
      access(1, 0, 2'd2, 4'd1, 8'hE4, 32'h0000_0800, "R7 small sub2 write");
      access(0, 0, 2'd2, 4'd1, 8'hE4, 32'h0000_C000, "R7 small sub0");
      access(0, 0, 2'd0, 4'd1, 8'hE4, 32'h0000_CC00, "R7 section single field");
      access(0, 0, 2'd3, 4'd1, 8'hE4, 32'h0000_CC00, "R7 tiny single field");

      // R10 software loads of the fault registers
      @(negedge clk);
      fsr_we = 1'b1; fsr_wdata = 8'h5A; far_we = 1'b1; far_wdata = 32'hDEAD_BEEF;
      m_fsr = 9'h05A; m_far = 32'hDEAD_BEEF;
      @(negedge clk);
      fsr_we = 1'b0; far_we = 1'b0;
      #1;
      chk("R10 fsr load", 32'(fsr_q), 32'h05A);
      chk("R10 far load", far_q, 32'hDEAD_BEEF);

      // R11 capture beats a same-cycle write; a granted access lets the write land
      access(0, 1, 2'd0, 4'd0, 8'hFF, 32'h1234_5678, "R11 capture wins", 1'b1, 8'h33, 32'h0);
      access(0, 1, 2'd0, 4'd3, 8'hFF, 32'h0000_1000, "R11 write on grant", 1'b1, 8'h77, 32'hCAFE_0000);

      // R13 inputs without acc_valid change nothing
      @(negedge clk);
      acc_write = 1'b1; acc_priv = 1'b0; desc_dom = 4'd0; desc_kind = 2'd0;
      acc_va = 32'hFFFF_FFFF;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1;
         chk("R13 no response", 32'(resp_valid), 0);
         chk("R13 far held", far_q, m_far);
         chk("R13 fsr held", 32'(fsr_q), 32'(m_fsr));
      end

      // R12 translation off
      mmu_en = 1'b0;
      access(0, 1, 2'd0, 4'd0, 8'hFF, 32'h0BAD_0000, "R12 deny domain off");
      access(1, 0, 2'd2, 4'd1, 8'h55, 32'h0BAD_0400, "R12 client AP01 off");

      repeat (3) @(negedge clk);
      #1 chk("R2 all responses seen", 32'(q_req.size()), 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule